// File: doc/BRIEF.md
# Shadowed RAM Store/Recall Controller

This block is a clocked model of a small static RAM of 64 words by 4 bits. A nonvolatile shadow bank, held here in registers, backs up every bit. The host reads and writes the RAM one word at a time. It uses an active-low chip select and an active-low write enable. An output-enable flag stands in for a tri-state data bus.

Two further active-low request inputs move data between the arrays. A store copies the whole RAM into the shadow bank. A recall copies the whole shadow bank back into the RAM. A request takes effect only after its input has stayed low for a qualifying number of cycles, and only one transfer can run at a time. Once a transfer is committed it runs for a fixed number of cycles, whatever the inputs do. While it runs, the block raises a busy flag and blanks the read path.

A recall beats a store. A low-supply flag blocks every store. If a store is committed while the host is writing, the word being written becomes corrupt, and so does its shadow copy. All timing is set by parameters counted in clock cycles.

Top module: `shadow_ram_ctl`

## Requirements
- R1: With `cs_n`=0, `we_n`=1, `store_n`=1, `recall_n`=1 and `busy`=0, `oe` is 1 and `dout` shows the RAM word at `addr` in the same cycle.
- R2: With `cs_n`=0, `we_n`=0, `store_n`=1, `recall_n`=1 and `busy`=0, the next rising edge writes `din` into the RAM word at `addr`. A read in the following cycle returns it.
- R3: When `cs_n`=1 the block is in standby: `oe` is 0 and no RAM word changes, whatever `we_n`, `addr` and `din` are.
- R4: A store is committed on the edge at which `store_n` has been sampled low for `STORE_QUAL` consecutive edges. A shorter low pulse is dropped: `busy` stays 0 and the shadow bank is unchanged. `cs_n`, `we_n` and `addr` have no effect on qualification.
- R5: After a store is committed, `busy` is 1 for exactly `STORE_LEN` cycles. During that time every RAM word is copied into the shadow bank. `store_n` is ignored after commitment, and a new store needs `store_n` to return high first.
- R6: A recall is committed on the edge at which `recall_n` has been sampled low for `RECALL_QUAL` consecutive edges. A shorter low pulse is dropped with no effect on `busy` or on the RAM.
- R7: After a recall is committed, `busy` is 1 for exactly `RECALL_LEN` cycles. During that time every shadow word is copied into the RAM. Reads after `busy` falls return the recalled data.
- R8: When `recall_n` and `store_n` go low together, the recall is performed and the store is not. A store cannot qualify while `recall_n` is low.
- R9: While `busy` is 1, store and recall requests are ignored. A pulse that both begins and ends inside a transfer starts nothing.
- R10: While `busy` is 1, or while `store_n` or `recall_n` is low, `oe` is 0 and host writes do not change the RAM.
- R11: While `low_supply` is 1, no store can be committed.
- R12: If a store is committed in a cycle with `cs_n`=0 and `we_n`=0, the RAM word at `addr` becomes `POISON`, and so does its shadow copy. `POISON` defaults to all ones.
- R13: Reset clears `busy` and both qualifiers. The shadow bank keeps its contents through reset, so a recall after reset restores the data stored before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when `oe` is 0 |
| oe | output | 1 | High when `dout` carries valid read data |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| store_n | input | 1 | Store request (RAM to shadow), active low |
| recall_n | input | 1 | Recall request (shadow to RAM), active low |
| low_supply | input | 1 | High when the supply is too low to store |
| busy | output | 1 | High while a committed transfer runs |

## Verification
The bench keeps the full 64 x 4 geometry, so every address can be written and read back. It shrinks the timing to `STORE_QUAL`=3, `RECALL_QUAL`=4, `STORE_LEN`=70 and `RECALL_LEN`=66. With these values, pulses one cycle short of qualification and exact busy lengths can be checked in a few hundred cycles. Because the two transfer lengths differ, the busy length shows which operation ran, which settles the priority case. A recall then exposes the shadow contents through the ordinary read path.

// File: rtl/shadow_ram_pkg.sv
package shadow_ram_pkg;

    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_STORE  = 2'd1,
        XF_RECALL = 2'd2
    } xfer_op_e;

    // Bits needed to hold the value v (at least one).
    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pulse_qual.sv
// Counts consecutive low samples of a request; fires once per low period.
module pulse_qual #(
    parameter int unsigned QUAL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    input  logic enable,
    output logic fire
);
    import shadow_ram_pkg::*;

    localparam int unsigned CW = bits_for(QUAL);
    localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

    logic [CW-1:0] run_q;
    logic          armed_q;

    assign fire = enable && armed_q && !req_n && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            armed_q <= 1'b1;
        end else begin
            if (req_n)
                armed_q <= 1'b1;
            else if (fire)
                armed_q <= 1'b0;

            if (req_n || !enable || !armed_q || fire)
                run_q <= '0;
            else
                run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/xfer_seq.sv
// Whole-array transfer sequencer: one word per cycle, then holds busy to the full length.
module xfer_seq #(
    parameter int unsigned DEPTH      = 64,
    parameter int unsigned STORE_LEN  = 100,
    parameter int unsigned RECALL_LEN = 100
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            store_go,
    input  logic                            recall_go,
    output shadow_ram_pkg::xfer_op_e        op,
    output logic                            busy,
    output logic                            copy_en,
    output logic [$clog2(DEPTH)-1:0]        idx
);
    import shadow_ram_pkg::*;

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned TW = bits_for(max_of(STORE_LEN, RECALL_LEN));
    localparam logic [TW-1:0] ST_LAST = TW'(STORE_LEN - 1);
    localparam logic [TW-1:0] RC_LAST = TW'(RECALL_LEN - 1);
    localparam logic [AW:0]   END_POS = (AW + 1)'(DEPTH);

    xfer_op_e      op_q;
    logic [TW-1:0] tick_q;
    logic [AW:0]   pos_q;
    logic [TW-1:0] last;

    assign op      = op_q;
    assign busy    = (op_q != XF_IDLE);
    assign copy_en = busy && (pos_q != END_POS);
    assign idx     = pos_q[AW-1:0];
    assign last    = (op_q == XF_STORE) ? ST_LAST : RC_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= XF_IDLE;
            tick_q <= '0;
            pos_q  <= '0;
        end else if (op_q == XF_IDLE) begin
            tick_q <= '0;
            pos_q  <= '0;
            if (recall_go)
                op_q <= XF_RECALL;
            else if (store_go)
                op_q <= XF_STORE;
        end else begin
            tick_q <= tick_q + 1'b1;
            if (pos_q != END_POS)
                pos_q <= pos_q + 1'b1;
            if (tick_q == last)
                op_q <= XF_IDLE;
        end
    end

endmodule

// File: rtl/shadow_ram_ctl.sv
module shadow_ram_ctl #(
    parameter int unsigned AW          = 6,
    parameter int unsigned DW          = 4,
    parameter int unsigned STORE_QUAL  = 25,
    parameter int unsigned RECALL_QUAL = 38,
    parameter int unsigned STORE_LEN   = 1250000,
    parameter int unsigned RECALL_LEN  = 175,
    parameter logic [DW-1:0] POISON    = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          oe,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          store_n,
    input  logic          recall_n,
    input  logic          low_supply,
    output logic          busy
);
    import shadow_ram_pkg::*;

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] ram_q    [DEPTH];
    logic [DW-1:0] shadow_q [DEPTH];

    xfer_op_e      xf_op;
    logic          copy_en;
    logic [AW-1:0] copy_idx;
    logic          store_go, recall_go;
    logic          host_ok, rd_en, wr_en, collide;

    pulse_qual #(.QUAL(STORE_QUAL)) u_store_q (
        .clk    (clk),
        .rst    (rst),
        .req_n  (store_n),
        .enable (!busy && recall_n && !low_supply),
        .fire   (store_go)
    );

    pulse_qual #(.QUAL(RECALL_QUAL)) u_recall_q (
        .clk    (clk),
        .rst    (rst),
        .req_n  (recall_n),
        .enable (!busy),
        .fire   (recall_go)
    );

    xfer_seq #(
        .DEPTH      (DEPTH),
        .STORE_LEN  (STORE_LEN),
        .RECALL_LEN (RECALL_LEN)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .store_go  (store_go),
        .recall_go (recall_go),
        .op        (xf_op),
        .busy      (busy),
        .copy_en   (copy_en),
        .idx       (copy_idx)
    );

    assign host_ok = !cs_n && store_n && recall_n && !busy;
    assign rd_en   = host_ok && we_n;
    assign wr_en   = host_ok && !we_n;
    assign collide = store_go && !recall_go && !cs_n && !we_n;

    assign oe   = rd_en;
    assign dout = rd_en ? ram_q[addr] : '0;

    // RAM: recall copy, store/write collision, or host write.
    always_ff @(posedge clk) begin
        if (copy_en && xf_op == XF_RECALL)
            ram_q[copy_idx] <= shadow_q[copy_idx];
        else if (collide)
            ram_q[addr] <= POISON;
        else if (wr_en)
            ram_q[addr] <= din;
    end

    // Shadow bank: never reset, written only by a store.
    always_ff @(posedge clk) begin
        if (copy_en && xf_op == XF_STORE)
            shadow_q[copy_idx] <= ram_q[copy_idx];
    end

endmodule

// File: rtl/shadow_ram_chk.sv
module shadow_ram_chk #(
    parameter int unsigned AW          = 6,
    parameter int unsigned DW          = 4,
    parameter int unsigned STORE_QUAL  = 25,
    parameter int unsigned RECALL_QUAL = 38,
    parameter int unsigned STORE_LEN   = 1250000,
    parameter int unsigned RECALL_LEN  = 175
) (
    input logic                     clk,
    input logic                     rst,
    input logic [AW-1:0]            addr,
    input logic                     cs_n,
    input logic                     store_n,
    input logic                     recall_n,
    input logic                     low_supply,
    input logic                     busy,
    input shadow_ram_pkg::xfer_op_e xf_op,
    input logic [DW-1:0]            cur_word
);
    import shadow_ram_pkg::*;

    logic [15:0]  st_run, rc_run;
    int unsigned  busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_run   <= '0;
            rc_run   <= '0;
            busy_run <= 0;
        end else begin
            st_run   <= store_n  ? 16'd0 : ((st_run == 16'hFFFF) ? st_run : st_run + 1'b1);
            rc_run   <= recall_n ? 16'd0 : ((rc_run == 16'hFFFF) ? rc_run : rc_run + 1'b1);
            busy_run <= busy ? busy_run + 1 : 0;
        end
    end

    assert_standby_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !busy) |=> (!$stable(addr) || $stable(cur_word)));

    assert_store_qual_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && xf_op == XF_STORE) |-> (32'(st_run) >= STORE_QUAL));

    assert_recall_qual_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && xf_op == XF_RECALL) |-> (32'(rc_run) >= RECALL_QUAL));

    assert_store_len_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(xf_op) == XF_STORE) |-> (busy_run == STORE_LEN));

    assert_recall_len_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(xf_op) == XF_RECALL) |-> (busy_run == RECALL_LEN));

    assert_recall_wins_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && $past(!recall_n)) |-> (xf_op == XF_RECALL));

    assert_lowsup_block_R11: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && xf_op == XF_STORE) |-> !$past(low_supply));

    assert_store_ram_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && xf_op == XF_STORE) |=> (!$stable(addr) || $stable(cur_word)));

endmodule

bind shadow_ram_ctl shadow_ram_chk #(
    .AW          (AW),
    .DW          (DW),
    .STORE_QUAL  (STORE_QUAL),
    .RECALL_QUAL (RECALL_QUAL),
    .STORE_LEN   (STORE_LEN),
    .RECALL_LEN  (RECALL_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .cs_n       (cs_n),
    .store_n    (store_n),
    .recall_n   (recall_n),
    .low_supply (low_supply),
    .busy       (busy),
    .xf_op      (xf_op),
    .cur_word   (ram_q[addr])
);

// File: tb/shadow_ram_ctl_test.sv
`timescale 1ns/1ps
module shadow_ram_ctl_test;

    localparam int AW = 6;
    localparam int DW = 4;
    localparam int SQ = 3;
    localparam int RQ = 4;
    localparam int SL = 70;
    localparam int RL = 66;
    localparam int N  = 1 << AW;
    localparam logic [DW-1:0] PZ = 4'hF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          oe, busy;
    logic          cs_n = 1'b1, we_n = 1'b1, store_n = 1'b1, recall_n = 1'b1, low_supply = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    shadow_ram_ctl #(
        .AW(AW), .DW(DW), .STORE_QUAL(SQ), .RECALL_QUAL(RQ),
        .STORE_LEN(SL), .RECALL_LEN(RL), .POISON(PZ)
    ) uut (
        .clk(clk), .rst(rst), .addr(addr), .din(din), .dout(dout), .oe(oe),
        .cs_n(cs_n), .we_n(we_n), .store_n(store_n), .recall_n(recall_n),
        .low_supply(low_supply), .busy(busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [DW-1:0] pat(input int sel, input int a);
        case (sel)
            0:       return DW'((a * 5 + 1) & 15);
            1:       return DW'((a * 3 + 7) & 15);
            2:       return DW'((a * 7 + 2) & 15);
            default: return DW'((~a) & 15);
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cs_n = 1'b1; we_n = 1'b1; store_n = 1'b1; recall_n = 1'b1;
    endtask

    task automatic write_word(input int a, input logic [DW-1:0] d);
        cs_n = 1'b0; we_n = 1'b0; addr = AW'(a); din = d;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic fill(input int sel);
        for (int a = 0; a < N; a++) write_word(a, pat(sel, a));
    endtask

    task automatic read_expect(input int a, input logic [DW-1:0] exp, input string tag);
        cs_n = 1'b0; we_n = 1'b1; addr = AW'(a);
        #1;
        check({tag, " oe"}, int'(oe), 1);
        check({tag, " data"}, int'(dout), int'(exp));
        cs_n = 1'b1;
    endtask

    // Compare the whole RAM to pattern sel; optional poisoned address.
    task automatic read_all(input int sel, input int pz_addr, input string tag);
        for (int a = 0; a < N; a++)
            read_expect(a, (a == pz_addr) ? PZ : pat(sel, a), tag);
    endtask

    task automatic count_busy(output int n, output int oe_seen);
        n = 0; oe_seen = 0;
        while (busy && n < 1000) begin
            n++;
            if (oe) oe_seen++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(input int cycles, input string tag);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (busy) seen++;
        end
        check(tag, seen, 0);
    endtask

    task automatic do_recall(input string tag);
        int n, o;
        recall_n = 1'b0;
        repeat (RQ) @(negedge clk);
        recall_n = 1'b1;
        check({tag, " busy after qual"}, int'(busy), 1);
        count_busy(n, o);
        check({tag, " recall length"}, n, RL);
    endtask

    initial begin
        int n, o;
        idle_inputs();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R13: reset state, R3: standby output off
        check("R13 busy after reset", int'(busy), 0);
        check("R3 oe in standby", int'(oe), 0);

        // R2, R1: exhaustive write and read back
        fill(0);
        read_all(0, -1, "R1 R2 readback");

        // R3: write attempt in standby ignored
        cs_n = 1'b1; we_n = 1'b0; addr = 6'd3; din = ~pat(0, 3);
        #1 check("R3 oe standby write", int'(oe), 0);
        @(negedge clk);
        we_n = 1'b1;
        read_expect(3, pat(0, 3), "R3 standby hold");

        // R5, R10, R4: first store, store_n held low past the end
        cs_n = 1'b0; we_n = 1'b1; addr = 6'd7; store_n = 1'b0;
        repeat (SQ) @(negedge clk);
        check("R4 store commits at qual", int'(busy), 1);
        count_busy(n, o);
        check("R5 store length", n, SL);
        check("R10 oe blank during store", o, 0);
        quiet(8, "R5 no retrigger while held");
        idle_inputs();

        // overwrite RAM, then pulses one cycle short
        fill(1);
        store_n = 1'b0;
        repeat (SQ - 1) @(negedge clk);
        store_n = 1'b1;
        quiet(6, "R4 short store dropped");
        recall_n = 1'b0;
        repeat (RQ - 1) @(negedge clk);
        recall_n = 1'b1;
        quiet(6, "R6 short recall dropped");
        read_all(1, -1, "R6 RAM kept after short recall");

        // R7, R9, R10: recall with writes and a store pulse inside busy
        recall_n = 1'b0;
        repeat (RQ) @(negedge clk);
        recall_n = 1'b1;
        check("R6 recall commits at qual", int'(busy), 1);
        n = 0; o = 0;
        cs_n = 1'b0; we_n = 1'b0; addr = 6'd5; din = 4'hE;
        while (busy && n < 1000) begin
            if (n == 10) store_n = 1'b0;
            if (n == 10 + SQ + 2) store_n = 1'b1;
            if (oe) o++;
            n++;
            @(negedge clk);
        end
        idle_inputs();
        check("R7 recall length", n, RL);
        check("R10 oe blank during recall", o, 0);
        quiet(8, "R9 store pulse inside busy ignored");
        read_all(0, -1, "R7 R10 recalled data");

        // R8: simultaneous requests -> recall only (length tells)
        fill(2);
        store_n = 1'b0; recall_n = 1'b0;
        repeat (RQ) @(negedge clk);
        store_n = 1'b1; recall_n = 1'b1;
        count_busy(n, o);
        check("R8 recall chosen", n, RL);
        read_all(0, -1, "R8 RAM from shadow");

        // R11: low supply blocks store
        fill(2);
        low_supply = 1'b1;
        store_n = 1'b0;
        repeat (SQ + 3) @(negedge clk);
        check("R11 store blocked", int'(busy), 0);
        store_n = 1'b1;
        @(negedge clk);
        low_supply = 1'b0;
        do_recall("R11");
        read_all(0, -1, "R11 shadow unchanged");

        // R12: store committed during a host write
        fill(2);
        cs_n = 1'b0; we_n = 1'b0; addr = 6'd9; din = 4'h3; store_n = 1'b0;
        repeat (SQ) @(negedge clk);
        idle_inputs();
        check("R12 store committed", int'(busy), 1);
        count_busy(n, o);
        check("R12 store length", n, SL);
        read_expect(9, PZ, "R12 RAM word poisoned");
        read_expect(8, pat(2, 8), "R12 neighbour intact");

        // R13: shadow survives reset
        fill(3);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R13 busy after second reset", int'(busy), 0);
        do_recall("R13");
        read_all(2, 9, "R12 R13 shadow after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule